// File: doc/BRIEF.md
# I2C Address Space Scanner

This controller sits above a byte-level I2C master and probes every 7-bit address in both directions, so software or a test sequencer can find which devices are present on a bus. It walks the 8-bit address byte from 0x00 up to 0xFF. The even bytes are write probes and the odd bytes are read probes. For each probe it issues a short command sequence to the byte master and records whether the address byte was acknowledged. Each acknowledged probe is reported once on a result strobe, as the raw 8-bit address byte. Shifting that byte right by one gives the 7-bit address, and bit 0 gives the direction. For example, 0xA0 and 0xA1 both belong to device 0x50.

A scan begins on a start pulse. Before any bus traffic, the block checks that both bus lines are high. A line held low means the pull-ups are missing or the bus is shorted. If either line is low, the scan is abandoned at once with an error flag, and no device is reported.

When a slave acknowledges a read probe, it starts driving data and would not see a STOP. The block therefore reads one dummy byte, answers it with a NACK, and only then issues STOP. This ends the transfer cleanly.

Top module: `i2c_addr_scan`

## Requirements
- R1: After reset the block is idle. `busy_o`, `cmd_valid_o`, `hit_valid_o`, `done_o` and `err_pullup_o` are low, and `dev_count_o` is 0.
- R2: A start pulse taken while idle clears `err_pullup_o` and `dev_count_o`. The block then samples both lines through a SYNC_STAGES-flop synchroniser for CHECK_CYC cycles. On the first low sample, `err_pullup_o` is set and `done_o` pulses on the next clock edge. No command is then issued and no hit is reported. Line levels have no effect outside this check.
- R3: Probes run in strictly ascending order of the address byte, 0x00 to 0xFF. The byte is sent as `cmd_data_o` with a WRITE command.
- R4: A write probe (byte bit 0 = 0) issues exactly START, then WRITE of the byte, then STOP. The op encoding on `cmd_op_o` is START=0, STOP=1, WRITE=2, READ=3. Every command completes on one `rsp_valid_i` pulse. For a WRITE, `rsp_ack_i` high on that pulse means the byte was acknowledged.
- R5: A read probe (bit 0 = 1) that is acknowledged issues START, WRITE, READ with `cmd_nack_o`=1, and then STOP. A READ is never issued after an unacknowledged address.
- R6: A read probe that is not acknowledged issues START, WRITE, then STOP directly.
- R7: For every acknowledged probe, `hit_valid_o` is high for one cycle with `hit_byte_o` equal to the address byte. This happens in the cycle after the STOP response of that probe is sampled. There is no hit at any other time.
- R8: `dev_count_o` increments in the same cycle as each hit. At the end of a scan it equals the number of acknowledged probes.
- R9: `done_o` is a one-cycle pulse. For a completed scan it rises in the cycle after the STOP response of probe 0xFF, and `busy_o` falls at the same time.
- R10: While `cmd_valid_o` is high and `cmd_ready_i` is low, the command stays valid and its op, data and NACK flag do not change.
- R11: A start pulse while `busy_o` is high is ignored. The running scan continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start-scan pulse, taken when idle |
| scl_in | input | 1 | Sensed level of the clock line |
| sda_in | input | 1 | Sensed level of the data line |
| cmd_valid_o | output | 1 | Command to byte master is valid |
| cmd_ready_i | input | 1 | Byte master accepts the command |
| cmd_op_o | output | 2 | Op: START=0, STOP=1, WRITE=2, READ=3 |
| cmd_data_o | output | 8 | Address byte for WRITE, else 0 |
| cmd_nack_o | output | 1 | Answer the READ byte with NACK |
| rsp_valid_i | input | 1 | Command completed |
| rsp_ack_i | input | 1 | Slave acknowledged the WRITE byte |
| hit_valid_o | output | 1 | One-cycle strobe per acknowledged probe |
| hit_byte_o | output | 8 | Raw acknowledged address byte |
| dev_count_o | output | 9 | Number of acknowledged probes this scan |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle end-of-scan pulse |
| err_pullup_o | output | 1 | Line found low before scanning |

## Verification
Each hit, count step and, for probe 0xFF, the end pulse is due one clock edge after the STOP response is sampled. The bench raises that response on a falling edge and compares the result strobe, byte and count on the very next falling edge. The aborted scan is due two edges after the start pulse is driven: one edge to leave idle and one to sample the low line. The bench samples `done_o` exactly there and expects it low again one cycle later. Every accepted command is compared against an expected queue built from the device map. Between acceptances, a withheld ready is used to check that the command is held steady.

// File: rtl/scan_pkg.sv
// scan_pkg: shared encodings for the address scanner.
// Assumes a 2-bit command op toward a byte-level I2C master.
package scan_pkg;
    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_STOP  = 2'd1,
        OP_WRITE = 2'd2,
        OP_READ  = 2'd3
    } scan_op_e;

    typedef enum logic [1:0] {
        STEP_BEGIN,
        STEP_ADDR,
        STEP_DUMMY,
        STEP_END
    } probe_step_e;

    typedef enum logic [1:0] {
        PH_ISSUE_IDLE,
        PH_ISSUE,
        PH_WAIT
    } probe_phase_e;

    typedef enum logic [1:0] {
        CT_IDLE,
        CT_CHECK,
        CT_LAUNCH,
        CT_PROBE
    } ctrl_state_e;
endpackage

// File: rtl/scan_pullup_gate.sv
// scan_pullup_gate: synchronises both bus line levels and, while enabled,
// requires CHECK_CYC consecutive high samples of both lines.
// Raises fail_o on the first low sample and pass_o on the last good sample.
// Assumes en drops in the cycle after pass_o or fail_o.
module scan_pullup_gate #(
    parameter int SYNC_STAGES = 2,
    parameter int CHECK_CYC   = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic scl_in,
    input  logic sda_in,
    output logic pass_o,
    output logic fail_o
);
    localparam int CW = $clog2(CHECK_CYC + 1);
    localparam logic [CW-1:0] LAST_SAMPLE = CW'(CHECK_CYC - 1);

    logic [1:0]    stage_q [SYNC_STAGES];
    logic [CW-1:0] good_cnt_q;
    logic          lines_high;

    // Synchroniser chain for both line levels; resets to "low" (conservative).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) stage_q[i] <= 2'b00;
        end else begin
            stage_q[0] <= {scl_in, sda_in};
            for (int i = 1; i < SYNC_STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    // Both lines high at the end of the synchroniser.
    always_comb lines_high = &stage_q[SYNC_STAGES-1];

    // Verdict for the current sample.
    always_comb begin
        fail_o = en && !lines_high;
        pass_o = en && lines_high && (good_cnt_q == LAST_SAMPLE);
    end

    // Count consecutive good samples while checking.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) good_cnt_q <= '0;
        else if (lines_high && !pass_o) good_cnt_q <= good_cnt_q + CW'(1);
    end
endmodule

// File: rtl/scan_addr_walk.sv
// scan_addr_walk: holds the address byte being probed and steps it upward.
// Bit 0 of the byte is the direction bit, so stepping alternates write/read.
module scan_addr_walk #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              step_i,
    output logic [BYTE_W-1:0] byte_o,
    output logic              last_o
);
    logic [BYTE_W-1:0] cur_q;

    // Address byte register: cleared at scan start, advanced per probe.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) cur_q <= '0;
        else if (step_i) cur_q <= cur_q + BYTE_W'(1);
    end

    // Last byte of the space reached when every bit is set.
    always_comb begin
        byte_o = cur_q;
        last_o = &cur_q;
    end
endmodule

// File: rtl/scan_probe_seq.sv
// scan_probe_seq: runs one probe on the byte master.
// The sequence is START, address WRITE, an optional dummy READ answered with
// NACK (only for an acknowledged read byte), then STOP.
// Assumes each command is accepted on valid&ready and ends on one rsp_valid_i.
module scan_probe_seq
    import scan_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              cmd_valid_o,
    input  logic              cmd_ready_i,
    output logic [1:0]        cmd_op_o,
    output logic [BYTE_W-1:0] cmd_data_o,
    output logic              cmd_nack_o,
    input  logic              rsp_valid_i,
    input  logic              rsp_ack_i,
    output logic              fin_o,
    output logic              fin_ack_o,
    output logic [BYTE_W-1:0] fin_byte_o
);
    probe_phase_e      phase_q;
    probe_step_e       step_q;
    logic [BYTE_W-1:0] byte_q;
    logic              ack_q;

    // Command fields follow the current step.
    always_comb begin
        cmd_valid_o = (phase_q == PH_ISSUE);
        cmd_nack_o  = (step_q == STEP_DUMMY);
        cmd_data_o  = (step_q == STEP_ADDR) ? byte_q : '0;
        unique case (step_q)
            STEP_BEGIN: cmd_op_o = OP_START;
            STEP_ADDR:  cmd_op_o = OP_WRITE;
            STEP_DUMMY: cmd_op_o = OP_READ;
            default:    cmd_op_o = OP_STOP;
        endcase
    end

    // Probe ends when the STOP response arrives.
    always_comb begin
        fin_o      = (phase_q == PH_WAIT) && rsp_valid_i && (step_q == STEP_END);
        fin_ack_o  = ack_q;
        fin_byte_o = byte_q;
    end

    // Step and handshake sequencing for one probe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_ISSUE_IDLE;
            step_q  <= STEP_BEGIN;
            byte_q  <= '0;
            ack_q   <= 1'b0;
        end else begin
            unique case (phase_q)
                PH_ISSUE_IDLE: begin
                    if (go_i) begin
                        byte_q  <= byte_i;
                        ack_q   <= 1'b0;
                        step_q  <= STEP_BEGIN;
                        phase_q <= PH_ISSUE;
                    end
                end
                PH_ISSUE: begin
                    if (cmd_ready_i) phase_q <= PH_WAIT;
                end
                default: begin
                    if (rsp_valid_i) begin
                        unique case (step_q)
                            STEP_BEGIN: begin
                                step_q  <= STEP_ADDR;
                                phase_q <= PH_ISSUE;
                            end
                            STEP_ADDR: begin
                                ack_q   <= rsp_ack_i;
                                step_q  <= (byte_q[0] && rsp_ack_i) ? STEP_DUMMY : STEP_END;
                                phase_q <= PH_ISSUE;
                            end
                            STEP_DUMMY: begin
                                step_q  <= STEP_END;
                                phase_q <= PH_ISSUE;
                            end
                            default: begin
                                step_q  <= STEP_BEGIN;
                                phase_q <= PH_ISSUE_IDLE;
                            end
                        endcase
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/scan_hit_tally.sv
// scan_hit_tally: turns finished probes into hit strobes and counts them.
// Assumes fin_i is a single-cycle strobe per probe.
module scan_hit_tally #(
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              fin_i,
    input  logic              ack_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              hit_valid_o,
    output logic [BYTE_W-1:0] hit_byte_o,
    output logic [CNT_W-1:0]  dev_count_o
);
    // Hit strobe, hit byte and running count of acknowledged probes.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            hit_valid_o <= 1'b0;
            hit_byte_o  <= '0;
            dev_count_o <= '0;
        end else begin
            hit_valid_o <= fin_i && ack_i;
            if (fin_i && ack_i) begin
                hit_byte_o  <= byte_i;
                dev_count_o <= dev_count_o + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/i2c_addr_scan.sv
// i2c_addr_scan: scans all address bytes through a byte-level I2C master,
// after a pull-up check, and reports the acknowledged bytes.
// Assumes the byte master performs all bit timing and returns one response
// per accepted command.
module i2c_addr_scan
    import scan_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int CHECK_CYC   = 4,
    parameter int SYNC_STAGES = 2,
    localparam int BYTE_W     = ADDR_W + 1,
    localparam int CNT_W      = ADDR_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              cmd_valid_o,
    input  logic              cmd_ready_i,
    output logic [1:0]        cmd_op_o,
    output logic [BYTE_W-1:0] cmd_data_o,
    output logic              cmd_nack_o,
    input  logic              rsp_valid_i,
    input  logic              rsp_ack_i,
    output logic              hit_valid_o,
    output logic [BYTE_W-1:0] hit_byte_o,
    output logic [CNT_W-1:0]  dev_count_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_pullup_o
);
    ctrl_state_e       st_q, st_d;
    logic              clear, go, step;
    logic              chk_pass, chk_fail;
    logic [BYTE_W-1:0] cur_byte;
    logic              cur_last;
    logic              fin, fin_ack;
    logic [BYTE_W-1:0] fin_byte;

    scan_pullup_gate #(.SYNC_STAGES(SYNC_STAGES), .CHECK_CYC(CHECK_CYC)) u_gate (
        .clk(clk), .rst_n(rst_n), .en(st_q == CT_CHECK),
        .scl_in(scl_in), .sda_in(sda_in),
        .pass_o(chk_pass), .fail_o(chk_fail)
    );

    scan_addr_walk #(.BYTE_W(BYTE_W)) u_walk (
        .clk(clk), .rst_n(rst_n), .clear_i(clear), .step_i(step),
        .byte_o(cur_byte), .last_o(cur_last)
    );

    scan_probe_seq #(.BYTE_W(BYTE_W)) u_probe (
        .clk(clk), .rst_n(rst_n), .go_i(go), .byte_i(cur_byte),
        .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i),
        .cmd_op_o(cmd_op_o), .cmd_data_o(cmd_data_o), .cmd_nack_o(cmd_nack_o),
        .rsp_valid_i(rsp_valid_i), .rsp_ack_i(rsp_ack_i),
        .fin_o(fin), .fin_ack_o(fin_ack), .fin_byte_o(fin_byte)
    );

    scan_hit_tally #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_tally (
        .clk(clk), .rst_n(rst_n), .clear_i(clear),
        .fin_i(fin), .ack_i(fin_ack), .byte_i(fin_byte),
        .hit_valid_o(hit_valid_o), .hit_byte_o(hit_byte_o),
        .dev_count_o(dev_count_o)
    );

    // Scan controller: idle -> line check -> launch/probe loop -> idle.
    always_comb begin
        st_d  = st_q;
        clear = 1'b0;
        go    = 1'b0;
        step  = 1'b0;
        unique case (st_q)
            CT_IDLE: begin
                if (start_i) begin
                    clear = 1'b1;
                    st_d  = CT_CHECK;
                end
            end
            CT_CHECK: begin
                if (chk_fail)      st_d = CT_IDLE;
                else if (chk_pass) st_d = CT_LAUNCH;
            end
            CT_LAUNCH: begin
                go   = 1'b1;
                st_d = CT_PROBE;
            end
            default: begin
                if (fin) begin
                    if (cur_last) begin
                        st_d = CT_IDLE;
                    end else begin
                        step = 1'b1;
                        st_d = CT_LAUNCH;
                    end
                end
            end
        endcase
    end

    // State, end pulse and sticky pull-up error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= CT_IDLE;
            done_o       <= 1'b0;
            err_pullup_o <= 1'b0;
        end else begin
            st_q   <= st_d;
            done_o <= ((st_q == CT_CHECK) && chk_fail)
                   || ((st_q == CT_PROBE) && fin && cur_last);
            if (clear)                            err_pullup_o <= 1'b0;
            else if ((st_q == CT_CHECK) && chk_fail) err_pullup_o <= 1'b1;
        end
    end

    // Busy whenever a scan is under way.
    always_comb busy_o = (st_q != CT_IDLE);
endmodule

// File: rtl/scan_probe_chk.sv
// scan_probe_chk: protocol properties for i2c_addr_scan, attached by bind.
// Tracks the last accepted command and last hit to relate ports over time.
module scan_probe_chk #(
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid_o,
    input logic              cmd_ready_i,
    input logic [1:0]        cmd_op_o,
    input logic [BYTE_W-1:0] cmd_data_o,
    input logic              cmd_nack_o,
    input logic              rsp_valid_i,
    input logic              rsp_ack_i,
    input logic              hit_valid_o,
    input logic [BYTE_W-1:0] hit_byte_o,
    input logic [CNT_W-1:0]  dev_count_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              err_pullup_o
);
    logic [1:0]        last_op_q;
    logic [BYTE_W-1:0] last_data_q;
    logic              rd_ok_q;
    logic              seen_hit_q;
    logic [BYTE_W-1:0] last_hit_q;

    // Track accepted command, read permission and last reported hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_op_q   <= 2'd0;
            last_data_q <= '0;
            rd_ok_q     <= 1'b0;
            seen_hit_q  <= 1'b0;
            last_hit_q  <= '0;
        end else begin
            if (cmd_valid_o && cmd_ready_i) begin
                last_op_q   <= cmd_op_o;
                last_data_q <= cmd_data_o;
                if (cmd_op_o == 2'd3) rd_ok_q <= 1'b0;
            end else if (rsp_valid_i && last_op_q == 2'd2) begin
                rd_ok_q <= rsp_ack_i && last_data_q[0];
            end
            if (done_o) begin
                seen_hit_q <= 1'b0;
            end else if (hit_valid_o) begin
                seen_hit_q <= 1'b1;
                last_hit_q <= hit_byte_o;
            end
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !cmd_valid_o);

    p_err_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        err_pullup_o |-> (dev_count_o == '0) && !hit_valid_o && !cmd_valid_o);

    p_hit_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid_o && seen_hit_q) |-> (hit_byte_o > last_hit_q));

    p_read_after_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && cmd_op_o == 2'd3) |-> (rd_ok_q && cmd_nack_o));

    p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid_o |-> (dev_count_o == $past(dev_count_o) + CNT_W'(1)));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_hold_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && !cmd_ready_i) |=>
            (cmd_valid_o && $stable(cmd_op_o) && $stable(cmd_data_o) && $stable(cmd_nack_o)));
endmodule

bind i2c_addr_scan scan_probe_chk #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i),
    .cmd_op_o(cmd_op_o), .cmd_data_o(cmd_data_o), .cmd_nack_o(cmd_nack_o),
    .rsp_valid_i(rsp_valid_i), .rsp_ack_i(rsp_ack_i),
    .hit_valid_o(hit_valid_o), .hit_byte_o(hit_byte_o),
    .dev_count_o(dev_count_o), .busy_o(busy_o), .done_o(done_o),
    .err_pullup_o(err_pullup_o)
);

// File: tb/i2c_addr_scan_bench.sv
// i2c_addr_scan_bench: scoreboard bench. A driver task fills expected command
// and hit queues from a device map; a byte-master model/monitor pops and compares.
module i2c_addr_scan_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       scl_in = 1'b1;
    logic       sda_in = 1'b1;
    logic       cmd_ready_i = 1'b0;
    logic       rsp_valid_i = 1'b0;
    logic       rsp_ack_i = 1'b0;
    logic       cmd_valid_o;
    logic [1:0] cmd_op_o;
    logic [7:0] cmd_data_o;
    logic       cmd_nack_o;
    logic       hit_valid_o;
    logic [7:0] hit_byte_o;
    logic [8:0] dev_count_o;
    logic       busy_o;
    logic       done_o;
    logic       err_pullup_o;

    int checks = 0;
    int errors = 0;
    int dev_map = 0;
    int bp_mode = 0;
    bit scan_active = 1'b0;
    int hits_seen = 0;
    logic [10:0] exp_cmd_q [$];
    logic [7:0]  exp_hit_q [$];

    i2c_addr_scan u_i2c_addr_scan (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .scl_in(scl_in), .sda_in(sda_in),
        .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i),
        .cmd_op_o(cmd_op_o), .cmd_data_o(cmd_data_o), .cmd_nack_o(cmd_nack_o),
        .rsp_valid_i(rsp_valid_i), .rsp_ack_i(rsp_ack_i),
        .hit_valid_o(hit_valid_o), .hit_byte_o(hit_byte_o),
        .dev_count_o(dev_count_o), .busy_o(busy_o), .done_o(done_o),
        .err_pullup_o(err_pullup_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit dev_acks(input logic [7:0] b);
        if (dev_map == 0)
            return (b[7:1] == 7'h50) || (b[7:1] == 7'h68) || (b == 8'h78) || (b == 8'h01);
        return (b == 8'h00) || (b[7:1] == 7'h7F);
    endfunction

    // Driver: expected commands {op,nack,data} and hits for a full scan.
    task automatic push_scan(output int exp_cnt);
        exp_cnt = 0;
        for (int b = 0; b < 256; b++) begin
            logic [7:0] by = 8'(b);
            exp_cmd_q.push_back({2'd0, 1'b0, 8'h00});
            exp_cmd_q.push_back({2'd2, 1'b0, by});
            if (by[0] && dev_acks(by)) exp_cmd_q.push_back({2'd3, 1'b1, 8'h00});
            exp_cmd_q.push_back({2'd1, 1'b0, 8'h00});
            if (dev_acks(by)) begin
                exp_hit_q.push_back(by);
                exp_cnt++;
            end
        end
    endtask

    // Byte-master model and result monitor, all on the falling edge.
    initial begin : model
        bit         s_valid = 1'b0;
        logic [1:0] s_op = 2'd0;
        logic [7:0] s_data = 8'h00;
        bit         s_nack = 1'b0;
        int         wait_cnt = 0;
        bit         pend_ack = 1'b0;
        bit         pend_stop = 1'b0;
        bit         stop_mon = 1'b0;
        logic [7:0] cur_byte = 8'h00;
        logic [7:0] stop_byte = 8'h00;
        int         cyc = 0;
        forever begin
            @(negedge clk);
            cyc++;
            if (stop_mon) begin
                bit eh;
                eh = dev_acks(stop_byte);
                check(hit_valid_o == eh, "R7", "hit strobe after STOP", hit_valid_o, eh);
                if (hit_valid_o && eh) begin
                    logic [7:0] eb;
                    eb = (exp_hit_q.size() > 0) ? exp_hit_q.pop_front() : 8'hxx;
                    check(hit_byte_o == eb, "R7", "hit byte", hit_byte_o, eb);
                    hits_seen++;
                    check(dev_count_o == 9'(hits_seen), "R8", "count at hit", dev_count_o, hits_seen);
                end
                check(done_o == (stop_byte == 8'hFF), "R9", "done after STOP",
                      done_o, (stop_byte == 8'hFF));
            end else if (scan_active && (hit_valid_o || done_o)) begin
                check(1'b0, "R7", "strobe outside STOP slot", {hit_valid_o, done_o}, 0);
            end
            stop_mon = 1'b0;
            rsp_valid_i = 1'b0;
            if (wait_cnt > 0) begin
                wait_cnt--;
                if (wait_cnt == 0) begin
                    rsp_valid_i = 1'b1;
                    rsp_ack_i = pend_ack;
                    stop_mon = pend_stop;
                end
            end else if (s_valid && cmd_ready_i) begin
                logic [10:0] got, exp;
                string tag;
                got = {s_op, s_nack, s_data};
                if (exp_cmd_q.size() == 0) begin
                    check(1'b0, "R2", "unexpected command", got, 0);
                end else begin
                    exp = exp_cmd_q.pop_front();
                    if (got[7:0] != exp[7:0])                tag = "R3";
                    else if (s_op == 2'd3 || exp[10:9] == 2'd3) tag = "R5";
                    else if (cur_byte[0] && s_op != 2'd2)   tag = "R6";
                    else                                     tag = "R4";
                    check(got == exp, tag, "command {op,nack,data}", got, exp);
                end
                if (s_op == 2'd2) cur_byte = s_data;
                pend_ack  = (s_op == 2'd2) ? dev_acks(s_data) : 1'b0;
                pend_stop = (s_op == 2'd1);
                stop_byte = cur_byte;
                cmd_ready_i = 1'b0;
                wait_cnt = LAT;
            end else if (s_valid && !cmd_ready_i) begin
                if (!(cmd_valid_o && cmd_op_o == s_op && cmd_data_o == s_data && cmd_nack_o == s_nack))
                    check(1'b0, "R10", "command changed while stalled",
                          {cmd_valid_o, cmd_op_o, cmd_data_o}, {1'b1, s_op, s_data});
            end
            if (wait_cnt == 0) cmd_ready_i = (bp_mode == 0) ? 1'b1 : ((cyc % 3) == 0);
            s_valid = cmd_valid_o;
            s_op    = cmd_op_o;
            s_data  = cmd_data_o;
            s_nack  = cmd_nack_o;
        end
    end

    task automatic run_scan(input int map, input int bp, input bit disturb);
        int exp_cnt;
        bit seen;
        dev_map = map;
        bp_mode = bp;
        scl_in = 1'b1;
        sda_in = 1'b1;
        repeat (4) @(negedge clk);
        push_scan(exp_cnt);
        hits_seen = 0;
        scan_active = 1'b1;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R2", "busy after start", busy_o, 1);
        check(err_pullup_o == 1'b0, "R2", "error cleared by start", err_pullup_o, 0);
        check(dev_count_o == 9'd0, "R2", "count cleared by start", dev_count_o, 0);
        seen = 1'b0;
        for (int i = 0; i < 30000; i++) begin
            @(negedge clk);
            if (disturb) begin
                if (i == 500) start_i = 1'b1;
                if (i == 501) start_i = 1'b0;
                if (i == 600) scl_in = 1'b0;
                if (i == 900) scl_in = 1'b1;
                if (i == 502) check(busy_o == 1'b1, "R11", "busy kept after extra start", busy_o, 1);
            end
            if (done_o) begin
                seen = 1'b1;
                break;
            end
        end
        check(seen, "R9", "scan finished", seen, 1);
        check(busy_o == 1'b0, "R9", "busy low with done", busy_o, 0);
        check(dev_count_o == 9'(exp_cnt), "R8", "final device count", dev_count_o, exp_cnt);
        check(exp_cmd_q.size() == 0, "R3", "all probes issued", exp_cmd_q.size(), 0);
        check(exp_hit_q.size() == 0, "R7", "all hits reported", exp_hit_q.size(), 0);
        if (disturb) check(dev_count_o == 9'(exp_cnt), "R11", "extra start had no effect", dev_count_o, exp_cnt);
        @(negedge clk);
        scan_active = 1'b0;
        check(done_o == 1'b0, "R9", "done is one cycle", done_o, 0);
        exp_cmd_q.delete();
        exp_hit_q.delete();
    endtask

    task automatic pullup_fail(input logic scl_v, input logic sda_v);
        scl_in = scl_v;
        sda_in = sda_v;
        repeat (4) @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(done_o == 1'b0, "R2", "no done one edge after start", done_o, 0);
        @(negedge clk);
        check(done_o == 1'b1, "R2", "abort done two edges after start", done_o, 1);
        check(err_pullup_o == 1'b1, "R2", "pull-up error flag", err_pullup_o, 1);
        check(dev_count_o == 9'd0, "R2", "no devices on abort", dev_count_o, 0);
        check(hit_valid_o == 1'b0, "R2", "no hit on abort", hit_valid_o, 0);
        @(negedge clk);
        check(done_o == 1'b0, "R9", "abort done is one cycle", done_o, 0);
        check(busy_o == 1'b0, "R2", "idle after abort", busy_o, 0);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (cmd_valid_o) check(1'b0, "R2", "command after abort", cmd_valid_o, 0);
        end
        check(err_pullup_o == 1'b1, "R2", "error flag sticky", err_pullup_o, 1);
        scl_in = 1'b1;
        sda_in = 1'b1;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy_o == 1'b0, "R1", "busy after reset", busy_o, 0);
        check(cmd_valid_o == 1'b0, "R1", "cmd_valid after reset", cmd_valid_o, 0);
        check(hit_valid_o == 1'b0, "R1", "hit after reset", hit_valid_o, 0);
        check(done_o == 1'b0, "R1", "done after reset", done_o, 0);
        check(err_pullup_o == 1'b0, "R1", "error after reset", err_pullup_o, 0);
        check(dev_count_o == 9'd0, "R1", "count after reset", dev_count_o, 0);
        run_scan(0, 0, 1'b0);
        pullup_fail(1'b1, 1'b0);
        pullup_fail(1'b0, 1'b1);
        run_scan(1, 1, 1'b1);
        run_scan(0, 1, 1'b0);
        finish_run();
    end
endmodule